// File: doc/BRIEF.md
# DMA Channel Request/Acknowledge Sequencer

This block runs one DMA channel. A requester holds a request line high; the channel answers with a one-clock acknowledge. It then reads one word from the source address and writes it to the destination address over a single memory port, and it counts down a programmed number of transfers. The channel stops when the count runs out, when the stop input is raised, when software clears its enable, or when the memory reports an error on either access. Every ending, normal or abnormal, gives the same end-of-operation pulse. The ending also clears the enable and leaves a two-bit code that records the cause.

Software writes the base addresses, the transfer count, two address-step bits and a mode bit on the configuration inputs, then pulses `en_set`. In demand mode each transfer needs its own request and gets its own acknowledge. In block mode one accepted request runs every remaining transfer back to back. After an acknowledge the channel ignores the request for a blanking window of `SRC_CYC + DST_CYC - 1` clocks, so a requester that drops its line inside that window does not start a second transfer.

Top module: `dma_hs_chan`

## Requirements
- R1: `ack` is high for exactly one clock. That clock is the first cycle of a source read (`mem_valid`=1, `mem_write`=0) that was started by an accepted request. In demand mode this happens once per transfer.
- R2: Each transfer reads the source for at least `SRC_CYC` cycles and then writes the read word to the destination for at least `DST_CYC` cycles. An access completes on its last cycle when `mem_ready` is high.
- R3: The request level is not sampled during the `SRC_CYC+DST_CYC-1` clocks that follow an acknowledge. With the request held high in demand mode, acknowledges are `SRC_CYC+DST_CYC+1` clocks apart. A request that is high only inside the window starts no transfer.
- R4: After each completed transfer, each address advances by `STEP_BYTES` when its step bit is 1 and stays fixed when its step bit is 0.
- R5: When the count reaches zero, `eop` is high for one clock in the cycle after the last write completes. `ch_status` becomes 0 and `ch_en` is low from that cycle on. In demand mode that cycle is `(N-1)*(SRC_CYC+DST_CYC+1)+SRC_CYC+DST_CYC` clocks after the first acknowledge; in block mode it is `N*(SRC_CYC+DST_CYC)` clocks after it.
- R6: `stop` ends the channel at any enabled time, including the gap between transfers, and sets `ch_status` to 1. Outside an access, `eop` lasts one clock.
- R7: When `stop` is sampled in cycle k (counted from 0) of an access of length L, the access is dropped (`mem_valid` low) and `eop` stays high for L-k clocks.
- R8: When `en_clr` is sampled while the channel is enabled, the channel ends with a one-clock `eop` and `ch_status` = 2.
- R9: An error flag on a completing source or destination access ends the channel with a one-clock `eop` and `ch_status` = 3. The failed transfer is not counted, and no further access is issued.
- R10: In block mode the channel gives one acknowledge per run, and each new source read starts in the cycle after the previous write completes.
- R11: Enabling with a count of 0 gives an `eop` one clock after enable, with `ch_status` = 0 and no memory access.
- R12: When `stop` and `req` are both high in the same sampled cycle, `stop` wins: no acknowledge, and `ch_status` = 1.
- R13: A disabled channel ignores `req`. `ch_status` holds its last code until the next ending, and it reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Level transfer request |
| ack | output | 1 | One-clock request acknowledge |
| stop | input | 1 | Forced termination |
| eop | output | 1 | End-of-operation indication |
| en_set | input | 1 | Load configuration and enable (idle only) |
| en_clr | input | 1 | Software clear of the enable |
| cfg_src | input | AW | Source base byte address |
| cfg_dst | input | AW | Destination base byte address |
| cfg_count | input | CW | Number of transfers |
| cfg_src_inc | input | 1 | 1: step the source address |
| cfg_dst_inc | input | 1 | 1: step the destination address |
| cfg_demand | input | 1 | 1: demand mode, 0: block mode |
| ch_en | output | 1 | Channel enabled and running |
| ch_status | output | 2 | Last end cause: 0 done, 1 stop, 2 software, 3 bus error |
| mem_valid | output | 1 | Memory access valid |
| mem_ready | input | 1 | Memory ready |
| mem_write | output | 1 | 1: write access, 0: read access |
| mem_addr | output | AW | Access byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with ready |
| mem_err | input | 1 | Error response, valid with ready |

## Verification
The hardest case to reach from the ports is a stop that lands in one chosen cycle of an access. Only then does the end pulse stretch, and each cycle gives a different length. The bench locks onto the acknowledge, which marks cycle 0 of the source read. It counts a fixed number of falling edges before raising `stop` for one clock, and it sweeps that offset across every cycle of both the read and the write. The main copy path is swept over all counts from 0 to 5, both step bits and both modes. The bench computes the destination memory image, the acknowledge spacing and the end cycle arithmetically.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_SRC   = 3'd2,
      ST_DST   = 3'd3,
      ST_DRAIN = 3'd4
   } chan_st_e;

   typedef enum logic [1:0] {
      END_DONE   = 2'd0,
      END_STOP   = 2'd1,
      END_SWOFF  = 2'd2,
      END_BUSERR = 2'd3
   } end_code_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dma_hs_ptr.sv
// Address pointer: loads a base, advances by a fixed byte step when enabled.
module dma_hs_ptr #(
   parameter int unsigned AW   = 16,
   parameter int unsigned STEP = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          adv,
   input  logic          inc_en,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   logic [AW-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ptr_q <= '0;
      else if (load)           ptr_q <= base;
      else if (adv && inc_en)  ptr_q <= ptr_q + STEP_V;
   end

   assign ptr = ptr_q;
endmodule

// File: rtl/dma_hs_blank.sv
// Request blanking window: busy for WIN clocks after load.
module dma_hs_blank #(
   parameter int unsigned WIN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy
);
   generate
      if (WIN == 1) begin : g_flop
         logic hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hold_q <= 1'b0;
            else        hold_q <= load;
         end
         assign busy = hold_q;
      end else begin : g_cnt
         localparam int unsigned BW = $clog2(WIN + 1);
         logic [BW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              left_q <= '0;
            else if (load)           left_q <= BW'(WIN);
            else if (left_q != '0)   left_q <= left_q - 1'b1;
         end
         assign busy = (left_q != '0);
      end
   endgenerate
endmodule

// File: rtl/dma_hs_acc_timer.sv
// Per-access cycle timer: marks first/last cycle, reports remaining cycles.
module dma_hs_acc_timer #(
   parameter int unsigned SRC_CYC = 2,
   parameter int unsigned DST_CYC = 3,
   parameter int unsigned RW      = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          is_dst,
   input  logic          ready,
   output logic          first,
   output logic          last,
   output logic [RW-1:0] remain
);
   logic [RW-1:0] cyc_q;
   logic [RW-1:0] len_m1;

   assign len_m1 = is_dst ? RW'(DST_CYC - 1) : RW'(SRC_CYC - 1);
   assign first  = (cyc_q == '0);
   assign last   = (cyc_q == len_m1);
   assign remain = len_m1 - cyc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cyc_q <= '0;
      else if (!run || (last && ready)) cyc_q <= '0;
      else if (!last)                 cyc_q <= cyc_q + 1'b1;
   end
endmodule

// File: rtl/dma_hs_chan.sv
module dma_hs_chan #(
   parameter int unsigned AW         = 16,
   parameter int unsigned DW         = 16,
   parameter int unsigned CW         = 8,
   parameter int unsigned SRC_CYC    = 2,
   parameter int unsigned DST_CYC    = 3,
   parameter int unsigned STEP_BYTES = DW / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   output logic          ack,
   input  logic          stop,
   output logic          eop,
   input  logic          en_set,
   input  logic          en_clr,
   input  logic [AW-1:0] cfg_src,
   input  logic [AW-1:0] cfg_dst,
   input  logic [CW-1:0] cfg_count,
   input  logic          cfg_src_inc,
   input  logic          cfg_dst_inc,
   input  logic          cfg_demand,
   output logic          ch_en,
   output logic [1:0]    ch_status,
   output logic          mem_valid,
   input  logic          mem_ready,
   output logic          mem_write,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_err
);
   import dma_hs_pkg::*;

   localparam int unsigned BLANK_WIN = SRC_CYC + DST_CYC - 1;
   localparam int unsigned LEN_MAX   = max2(SRC_CYC, DST_CYC);
   localparam int unsigned RW        = $clog2(LEN_MAX + 1);

   generate
      if (SRC_CYC < 1) begin : g_bad_src
         $error("SRC_CYC must be at least 1");
      end
      if (DST_CYC < 1) begin : g_bad_dst
         $error("DST_CYC must be at least 1");
      end
      if (CW < 1 || AW < 2 || DW < 8) begin : g_bad_width
         $error("CW, AW or DW too small");
      end
      if (STEP_BYTES >= (64'd1 << AW)) begin : g_bad_step
         $error("STEP_BYTES does not fit in AW");
      end
   endgenerate

   chan_st_e      st_q, st_d;
   end_code_e     code_q, code_d;
   logic [RW-1:0] drain_q, drain_d;
   logic [CW-1:0] left_q;
   logic [DW-1:0] data_q;
   logic          src_inc_q, dst_inc_q, demand_q, from_wait_q;

   logic          in_acc, acc_first, acc_last, acc_done, blank_busy;
   logic          end_go, load_cfg, src_adv, dst_adv;
   logic [RW-1:0] acc_remain;
   logic [AW-1:0] src_ptr, dst_ptr;

   assign in_acc   = (st_q == ST_SRC) || (st_q == ST_DST);
   assign acc_done = in_acc && acc_last && mem_ready;

   dma_hs_acc_timer #(.SRC_CYC(SRC_CYC), .DST_CYC(DST_CYC), .RW(RW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (in_acc),
      .is_dst (st_q == ST_DST),
      .ready  (mem_ready),
      .first  (acc_first),
      .last   (acc_last),
      .remain (acc_remain)
   );

   dma_hs_blank #(.WIN(BLANK_WIN)) u_blank (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ack),
      .busy  (blank_busy)
   );

   dma_hs_ptr #(.AW(AW), .STEP(STEP_BYTES)) u_src_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_cfg),
      .base   (cfg_src),
      .adv    (src_adv),
      .inc_en (src_inc_q),
      .ptr    (src_ptr)
   );

   dma_hs_ptr #(.AW(AW), .STEP(STEP_BYTES)) u_dst_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_cfg),
      .base   (cfg_dst),
      .adv    (dst_adv),
      .inc_en (dst_inc_q),
      .ptr    (dst_ptr)
   );

   // Next-state logic: stop > software clear > bus error > normal flow.
   always_comb begin
      st_d     = st_q;
      code_d   = END_DONE;
      end_go   = 1'b0;
      drain_d  = drain_q;
      load_cfg = 1'b0;
      src_adv  = 1'b0;
      dst_adv  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (en_set) begin
               load_cfg = 1'b1;
               st_d     = ST_WAIT;
            end
         end
         ST_WAIT: begin
            if (stop) begin
               end_go = 1'b1;
               code_d = END_STOP;
            end else if (en_clr) begin
               end_go = 1'b1;
               code_d = END_SWOFF;
            end else if (left_q == '0) begin
               end_go = 1'b1;
               code_d = END_DONE;
            end else if (req && !blank_busy) begin
               st_d = ST_SRC;
            end
         end
         ST_SRC, ST_DST: begin
            if (stop) begin
               end_go = 1'b1;
               code_d = END_STOP;
            end else if (en_clr) begin
               end_go = 1'b1;
               code_d = END_SWOFF;
            end else if (acc_done && mem_err) begin
               end_go = 1'b1;
               code_d = END_BUSERR;
            end else if (acc_done) begin
               if (st_q == ST_SRC) begin
                  src_adv = 1'b1;
                  st_d    = ST_DST;
               end else begin
                  dst_adv = 1'b1;
                  if (left_q == CW'(1)) begin
                     end_go = 1'b1;
                     code_d = END_DONE;
                  end else begin
                     st_d = demand_q ? ST_WAIT : ST_SRC;
                  end
               end
            end
         end
         ST_DRAIN: begin
            if (drain_q == '0) st_d = ST_IDLE;
            else               drain_d = drain_q - 1'b1;
         end
         default: st_d = ST_IDLE;
      endcase
      if (end_go) begin
         st_d    = ST_DRAIN;
         drain_d = (code_d == END_STOP && in_acc) ? acc_remain : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         code_q      <= END_DONE;
         drain_q     <= '0;
         left_q      <= '0;
         data_q      <= '0;
         src_inc_q   <= 1'b0;
         dst_inc_q   <= 1'b0;
         demand_q    <= 1'b0;
         from_wait_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         drain_q <= drain_d;
         if (end_go) code_q <= code_d;
         if (load_cfg) begin
            left_q    <= cfg_count;
            src_inc_q <= cfg_src_inc;
            dst_inc_q <= cfg_dst_inc;
            demand_q  <= cfg_demand;
         end else if (dst_adv) begin
            left_q <= left_q - 1'b1;
         end
         if (src_adv) data_q <= mem_rdata;
         if (st_q == ST_WAIT && st_d == ST_SRC)      from_wait_q <= 1'b1;
         else if (st_q == ST_DST && st_d == ST_SRC)  from_wait_q <= 1'b0;
      end
   end

   assign ack       = (st_q == ST_SRC) && acc_first && from_wait_q;
   assign eop       = (st_q == ST_DRAIN);
   assign ch_en     = (st_q == ST_WAIT) || in_acc;
   assign ch_status = code_q;
   assign mem_valid = in_acc;
   assign mem_write = (st_q == ST_DST);
   assign mem_addr  = (st_q == ST_DST) ? dst_ptr : src_ptr;
   assign mem_wdata = data_q;

endmodule

// File: rtl/dma_hs_chk.sv
module dma_hs_chk #(
   parameter int unsigned SRC_CYC = 2,
   parameter int unsigned DST_CYC = 3
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ack,
   input logic       eop,
   input logic       ch_en,
   input logic [1:0] ch_status,
   input logic       mem_valid,
   input logic       mem_write
);
   localparam int unsigned GAP = SRC_CYC + DST_CYC;
   localparam int unsigned GW  = $clog2(GAP + 2);

   logic [GW-1:0] since_q;
   logic          seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
         seen_q  <= 1'b0;
      end else if (ack) begin
         since_q <= GW'(1);
         seen_q  <= 1'b1;
      end else if (since_q < GW'(GAP)) begin
         since_q <= since_q + 1'b1;
      end
   end

   AST_ACK_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack); // R1
   AST_ACK_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (mem_valid && !mem_write)); // R1
   AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_write) |-> $past(mem_valid && !mem_write)); // R2
   AST_BLANK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (!seen_q || since_q >= GW'(GAP))); // R3
   AST_EOP_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      eop |-> !ch_en); // R5
   AST_EOP_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      eop |-> (!mem_valid && !ack)); // R7
   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_en && !eop && $past(!ch_en)) |-> $stable(ch_status)); // R13
endmodule

bind dma_hs_chan dma_hs_chk #(.SRC_CYC(SRC_CYC), .DST_CYC(DST_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ack       (ack),
   .eop       (eop),
   .ch_en     (ch_en),
   .ch_status (ch_status),
   .mem_valid (mem_valid),
   .mem_write (mem_write)
);

// File: tb/sim_dma_hs_chan.sv
module sim_dma_hs_chan;
   localparam int SC = 2;
   localparam int DC = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, stop = 1'b0, en_set = 1'b0, en_clr = 1'b0;
   logic [15:0] cfg_src = '0, cfg_dst = '0;
   logic [7:0]  cfg_count = '0;
   logic        cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0, cfg_demand = 1'b0;
   logic        ack, eop, ch_en, mem_valid, mem_write, mem_err;
   logic [1:0]  ch_status;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_ready = 1'b1;

   logic        clr_dst = 1'b0, err_rd = 1'b0, err_wr = 1'b0;
   int          err_idx = 0;
   logic [15:0] dmem [0:15];
   int          widx;
   int          checks = 0, errors = 0;

   always #5 clk = ~clk;

   dma_hs_chan #(.AW(16), .DW(16), .CW(8), .SRC_CYC(SC), .DST_CYC(DC)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .stop(stop), .eop(eop),
      .en_set(en_set), .en_clr(en_clr), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
      .cfg_count(cfg_count), .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
      .cfg_demand(cfg_demand), .ch_en(ch_en), .ch_status(ch_status),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_err(mem_err));

   function automatic logic [15:0] sval(input int i);
      return 16'h1100 + 16'(i * 291);
   endfunction

   // Memory: words 0..15 are a computed source, words 16..31 the destination.
   always_comb begin
      widx      = int'(mem_addr[5:1]);
      mem_rdata = (widx < 16) ? sval(widx) : dmem[widx-16];
      mem_err   = mem_valid && widx == err_idx &&
                  ((err_rd && !mem_write) || (err_wr && mem_write));
   end

   always @(posedge clk) begin
      if (clr_dst) begin
         for (int i = 0; i < 16; i++) dmem[i] <= '0;
      end else if (mem_valid && mem_ready && mem_write && !mem_err && widx >= 16) begin
         dmem[widx-16] <= mem_wdata;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic start(input int c, input bit si, input bit di, input bit dm);
      clr_dst = 1'b1;
      @(negedge clk);
      clr_dst     = 1'b0;
      cfg_src     = 16'd0;
      cfg_dst     = 16'd32;
      cfg_count   = 8'(c);
      cfg_src_inc = si;
      cfg_dst_inc = di;
      cfg_demand  = dm;
      en_set      = 1'b1;
      @(negedge clk);
      en_set = 1'b0;
   endtask

   // Wait for the end pulse to finish; returns its length.
   task automatic wait_eop(output int len);
      len = 0;
      for (int n = 0; n < 400; n++) begin
         if (eop) len++;
         else if (len > 0) break;
         @(negedge clk);
      end
   endtask

   task automatic run_xfer(input int c, input bit si, input bit di, input bit dm);
      int acks = 0, rel = -1, last_ack = 0, eop_len = 0, eop_rel = -1, bad_gap = 0;
      logic [15:0] expv [0:7];
      start(c, si, di, dm);
      req = 1'b1;
      for (int n = 0; n < 400; n++) begin
         if (rel >= 0) rel++;
         if (ack) begin
            if (rel < 0) rel = 0;
            else if (dm && (rel - last_ack) != SC + DC + 1) bad_gap++;
            last_ack = rel;
            acks++;
         end
         if (eop) begin
            if (eop_len == 0) eop_rel = rel;
            eop_len++;
         end else if (eop_len > 0) begin
            break;
         end
         @(negedge clk);
      end
      req = 1'b0;
      for (int i = 0; i < 8; i++) expv[i] = '0;
      for (int t = 0; t < c; t++) expv[di ? t : 0] = sval(si ? t : 0);
      if (c == 0) chk(acks == 0, "R11 no ack on zero count", acks, 0);
      else if (dm) chk(acks == c, "R1 demand ack count", acks, c);
      else chk(acks == 1, "R10 block ack count", acks, 1);
      chk(eop_len == 1, "R5 eop length", eop_len, 1);
      chk(ch_status == 2'd0, "R5 status done", ch_status, 0);
      chk(!ch_en, "R5 enable cleared", ch_en, 0);
      chk(bad_gap == 0, "R3 ack spacing", bad_gap, 0);
      if (c > 0) begin
         if (dm) chk(eop_rel == (c-1)*(SC+DC+1) + SC + DC, "R5 demand end cycle",
                     eop_rel, (c-1)*(SC+DC+1) + SC + DC);
         else    chk(eop_rel == c*(SC+DC), "R10 block end cycle", eop_rel, c*(SC+DC));
      end
      for (int i = 0; i < 8; i++)
         chk(dmem[i] == expv[i], "R2 R4 destination word", dmem[i], expv[i]);
   endtask

   task automatic stop_at(input int k);
      int len, lim, kk;
      start(4, 1'b1, 1'b1, 1'b1);
      req = 1'b1;
      for (int n = 0; n < 50 && !ack; n++) @(negedge clk);
      chk(ack, "R1 ack before stop", ack, 1);
      repeat (k) @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      req  = 1'b0;
      lim = (k < SC) ? SC : DC;
      kk  = (k < SC) ? k : k - SC;
      wait_eop(len);
      chk(len == lim - kk, "R7 stretched eop length", len, lim - kk);
      chk(ch_status == 2'd1, "R6 status stop", ch_status, 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int len, acks;
      repeat (3) @(negedge clk);
      chk(!ack && !eop && !ch_en && !mem_valid, "R13 reset outputs", {ack, eop, ch_en, mem_valid}, 0);
      chk(ch_status == 2'd0, "R13 reset status", ch_status, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Sweep: count, step bits and mode.
      for (int c = 0; c <= 5; c++)
         for (int m = 0; m < 8; m++)
            run_xfer(c, m[0], m[1], m[2]);

      // R7 / R6: stop at every cycle of the read and the write.
      for (int k = 0; k < SC + DC; k++) stop_at(k);

      // R6: stop in the gap between demand transfers.
      start(3, 1'b1, 1'b1, 1'b1);
      req = 1'b1;
      for (int n = 0; n < 50 && !ack; n++) @(negedge clk);
      @(negedge clk);
      req = 1'b0;
      repeat (SC + DC + 2) @(negedge clk);
      chk(ch_en && !eop, "R6 idle gap reached", ch_en, 1);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      wait_eop(len);
      chk(len == 1, "R6 gap stop eop length", len, 1);
      chk(ch_status == 2'd1, "R6 gap stop status", ch_status, 1);
      chk(dmem[0] == sval(0) && dmem[1] == 16'd0, "R6 one word copied", dmem[1], 0);

      // R12: stop and request together.
      start(2, 1'b1, 1'b1, 1'b1);
      req = 1'b1; stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      chk(!ack && eop, "R12 stop wins over request", ack, 0);
      wait_eop(len);
      req = 1'b0;
      chk(ch_status == 2'd1, "R12 status stop", ch_status, 1);

      // R8: software clear during a read.
      start(3, 1'b1, 1'b1, 1'b1);
      req = 1'b1;
      for (int n = 0; n < 50 && !ack; n++) @(negedge clk);
      en_clr = 1'b1;
      @(negedge clk);
      en_clr = 1'b0; req = 1'b0;
      wait_eop(len);
      chk(len == 1, "R8 eop length", len, 1);
      chk(ch_status == 2'd2, "R8 status software", ch_status, 2);

      // R9: read error on source word 2.
      err_rd = 1'b1; err_idx = 2; acks = 0;
      start(4, 1'b1, 1'b1, 1'b1);
      req = 1'b1; len = 0;
      for (int n = 0; n < 200; n++) begin
         if (ack) acks++;
         if (eop) len++;
         else if (len > 0) break;
         @(negedge clk);
      end
      req = 1'b0; err_rd = 1'b0;
      chk(ch_status == 2'd3, "R9 status read error", ch_status, 3);
      chk(len == 1, "R9 eop length", len, 1);
      chk(acks == 3, "R9 acks before read error", acks, 3);
      chk(dmem[1] == sval(1) && dmem[2] == 16'd0, "R9 no write after read error", dmem[2], 0);

      // R9: write error on destination word 1 (byte 34).
      err_wr = 1'b1; err_idx = 17; acks = 0;
      start(4, 1'b1, 1'b1, 1'b0);
      req = 1'b1; len = 0;
      for (int n = 0; n < 200; n++) begin
         if (ack) acks++;
         if (eop) len++;
         else if (len > 0) break;
         @(negedge clk);
      end
      req = 1'b0; err_wr = 1'b0;
      chk(ch_status == 2'd3, "R9 status write error", ch_status, 3);
      chk(dmem[0] == sval(0) && dmem[1] == 16'd0, "R9 failed write dropped", dmem[1], 0);

      // R3: request high only inside the blanking window is ignored.
      start(3, 1'b1, 1'b1, 1'b1);
      req = 1'b1;
      for (int n = 0; n < 50 && !ack; n++) @(negedge clk);
      acks = 1;
      for (int n = 1; n <= SC + DC - 1; n++) begin
         @(negedge clk);
         if (ack) acks++;
      end
      req = 1'b0;
      for (int n = 0; n < 10; n++) begin
         @(negedge clk);
         if (ack) acks++;
      end
      chk(acks == 1, "R3 blanked request ignored", acks, 1);
      chk(ch_en, "R3 channel still waiting", ch_en, 1);
      req = 1'b1;
      for (int n = 0; n < 3; n++) begin
         @(negedge clk);
         if (ack) acks++;
      end
      chk(acks == 2, "R3 later request accepted", acks, 2);
      req = 1'b0;
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      wait_eop(len);

      // R13: disabled channel ignores requests and holds its status.
      req = 1'b1; acks = 0;
      for (int n = 0; n < 10; n++) begin
         @(negedge clk);
         if (ack || mem_valid) acks++;
      end
      req = 1'b0;
      chk(acks == 0, "R13 idle ignores request", acks, 0);
      chk(ch_status == 2'd1, "R13 status held", ch_status, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule